// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block caches recent virtual-to-physical page translations for a 32-bit virtual, 28-bit physical machine with 64 KB pages. A lookup compares the upper 16 bits of the virtual address against every stored tag in the same cycle. A hit returns a 28-bit physical address, built from the stored 12-bit frame number and the unchanged 16-bit page offset. Each entry also holds read, write and execute rights, and the lookup checks the requested access against them.

When no valid entry matches, the block raises a miss and presents the page number to an external table walker. The walker answers with a refill write. A flush input empties the whole cache in one cycle, for use on a context switch.

Top module: `xlate_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses until a refill is written.
- R2: A refill written in one cycle is not visible to a lookup in that same cycle. A lookup of that page number in any later cycle hits, until the entry is evicted or flushed.
- R3: On a hit, `lk_paddr` equals the stored frame number concatenated with `lk_vaddr[15:0]`. When there is no hit, `lk_paddr` is zero.
- R4: `lk_miss` is high exactly when `lk_valid` is high and no valid entry holds `lk_vaddr[31:16]`. `miss_vpn` carries that page number during a miss and is zero otherwise. With `lk_valid` low, `lk_hit`, `lk_miss` and `lk_fault` are all low.
- R5: A cycle with `flush` high invalidates every entry and returns the victim pointer to entry 0, starting with the next cycle.
- R6: The rights field `fill_perm` uses bit 0 for read, bit 1 for write and bit 2 for execute. The access code `lk_acc` is 0 for read, 1 for write and 2 for execute. A hit whose access right is clear raises `lk_fault`, and code 3 faults on every hit. `lk_fault` is only ever high together with `lk_hit`, and the hit still returns its address.
- R7: A refill is placed by the first rule that applies. (a) A refill of a page number that is already cached overwrites that entry. (b) Otherwise it goes into the lowest-numbered invalid entry. (c) If every entry is valid, it goes into the entry under a round-robin pointer, which then advances and wraps from the last entry to 0. The pointer moves only under rule (c).
- R8: When `flush` and `fill_en` are high in the same cycle, the flush takes effect and the refill is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | A valid entry matched |
| lk_miss | output | 1 | Lookup found no valid entry |
| lk_fault | output | 1 | Hit with the access right not granted |
| lk_paddr | output | 28 | Translated physical address |
| miss_vpn | output | 16 | Page number handed to the walker on a miss |
| fill_en | input | 1 | Refill write strobe |
| fill_vpn | input | 16 | Page number of the refill |
| fill_ppn | input | 12 | Frame number of the refill |
| fill_perm | input | 3 | Rights of the refill: bit0 read, bit1 write, bit2 execute |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench targets refill ordering. A design that ignored the lowest-invalid rule, or advanced the round-robin pointer on non-victim refills, would evict the wrong page, and a later lookup would hit where a miss is expected. Refilling a page that is already cached checks that no duplicate is created. A design that duplicated it would lose an unrelated entry or return a stale frame number. A flush paired with a refill in the same cycle, followed by an immediate lookup, catches a design that gives the refill priority. The reserved access code and single-right pages catch a rights decoder that indexes the wrong bit.

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int N     = 16,
  parameter int VA_W  = 32,
  parameter int PA_W  = 28,
  parameter int OFS_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic [1:0]            lk_acc,
  output logic                  lk_hit,
  output logic                  lk_miss,
  output logic                  lk_fault,
  output logic [PA_W-1:0]       lk_paddr,
  output logic [VA_W-OFS_W-1:0] miss_vpn,
  input  logic                  fill_en,
  input  logic [VA_W-OFS_W-1:0] fill_vpn,
  input  logic [PA_W-OFS_W-1:0] fill_ppn,
  input  logic [2:0]            fill_perm,
  input  logic                  flush
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [VPN_W-1:0] tag_q  [N];
  logic [PPN_W-1:0] ppn_q  [N];
  logic [2:0]       perm_q [N];
  logic [N-1:0]     val_q;
  logic [IDX_W-1:0] rr_q;

  wire [VPN_W-1:0] lk_vpn = lk_vaddr[VA_W-1:OFS_W];
  logic [N-1:0] lk_match, fl_match;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign lk_match[i] = val_q[i] && (tag_q[i] == lk_vpn);
    assign fl_match[i] = val_q[i] && (tag_q[i] == fill_vpn);
  end

  logic [PPN_W-1:0] hit_ppn;
  logic [2:0]       hit_perm;
  logic [IDX_W-1:0] inv_idx, fm_idx, fill_idx;
  logic             perm_ok;

  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    inv_idx  = '0;
    fm_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        hit_ppn  = hit_ppn | ppn_q[i];
        hit_perm = hit_perm | perm_q[i];
      end
      if (!val_q[i])   inv_idx = IDX_W'(i);
      if (fl_match[i]) fm_idx  = IDX_W'(i);
    end
  end

  assign fill_idx = (|fl_match) ? fm_idx : (&val_q) ? rr_q : inv_idx;

  always_comb begin
    case (lk_acc)
      2'd0:    perm_ok = hit_perm[0];
      2'd1:    perm_ok = hit_perm[1];
      2'd2:    perm_ok = hit_perm[2];
      default: perm_ok = 1'b0;
    endcase
  end

  assign lk_hit   = lk_valid && (|lk_match);
  assign lk_miss  = lk_valid && !(|lk_match);
  assign lk_fault = lk_hit && !perm_ok;
  assign lk_paddr = lk_hit ? {hit_ppn, lk_vaddr[OFS_W-1:0]} : '0;
  assign miss_vpn = lk_miss ? lk_vpn : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      val_q <= '0;
      rr_q  <= '0;
    end else if (fill_en) begin
      val_q[fill_idx] <= 1'b1;
      if (!(|fl_match) && (&val_q))
        rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[fill_idx]  <= fill_vpn;
      ppn_q[fill_idx]  <= fill_ppn;
      perm_q[fill_idx] <= fill_perm;
    end
  end
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 28,
  parameter int OFS_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lk_valid,
  input logic [VA_W-1:0]       lk_vaddr,
  input logic                  lk_hit,
  input logic                  lk_miss,
  input logic                  lk_fault,
  input logic [PA_W-1:0]       lk_paddr,
  input logic                  fill_en,
  input logic [VA_W-OFS_W-1:0] fill_vpn,
  input logic [PA_W-OFS_W-1:0] fill_ppn,
  input logic                  flush
);
  p_fill_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) ##1 (lk_valid && lk_vaddr[VA_W-1:OFS_W] == $past(fill_vpn))
    |-> (lk_hit && lk_paddr[PA_W-1:OFS_W] == $past(fill_ppn)));

  p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss && !lk_fault));

  p_flush_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  p_fault_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  p_flush_beats_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fill_en) ##1 (lk_valid && lk_vaddr[VA_W-1:OFS_W] == $past(fill_vpn)) |-> lk_miss);
endmodule

bind xlate_cache xlate_cache_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
  .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush(flush)
);

// File: tb/xlate_cache_tb_top.sv
module xlate_cache_tb_top;
  localparam int N = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, lk_valid, fill_en, flush;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_acc;
  logic [15:0] fill_vpn, miss_vpn;
  logic [11:0] fill_ppn;
  logic [2:0]  fill_perm;
  logic lk_hit, lk_miss, lk_fault;
  logic [27:0] lk_paddr;

  xlate_cache #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .miss_vpn(miss_vpn), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_perm(fill_perm), .flush(flush)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_vpn [N];
  logic [11:0] m_ppn [N];
  logic [2:0]  m_perm [N];
  bit          m_val [N];
  int          m_rr;

  task automatic model_clear();
    for (int i = 0; i < N; i++) m_val[i] = 0;
    m_rr = 0;
  endtask

  task automatic model_fill(input logic [15:0] v, input logic [11:0] p, input logic [2:0] r);
    int slot = -1;
    for (int i = 0; i < N; i++) if (slot < 0 && m_val[i] && m_vpn[i] == v) slot = i;
    if (slot < 0) for (int i = 0; i < N; i++) if (slot < 0 && !m_val[i]) slot = i;
    if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
    m_val[slot] = 1; m_vpn[slot] = v; m_ppn[slot] = p; m_perm[slot] = r;
  endtask

  task automatic step(input bit v, input logic [31:0] va, input logic [1:0] acc,
                      input bit fe, input logic [15:0] fv, input logic [11:0] fp,
                      input logic [2:0] fr, input bit fl, input string tag);
    bit eh = 0, em = 0, ef = 0;
    logic [27:0] ep = '0;
    logic [15:0] ev = '0;
    string t;
    lk_valid = v; lk_vaddr = va; lk_acc = acc;
    fill_en = fe; fill_vpn = fv; fill_ppn = fp; fill_perm = fr; flush = fl;
    for (int i = 0; i < N; i++)
      if (v && m_val[i] && m_vpn[i] == va[31:16]) begin
        eh = 1; ep = {m_ppn[i], va[15:0]};
        ef = (acc == 2'd3) ? 1'b1 : !m_perm[i][acc];
      end
    if (v && !eh) begin em = 1; ev = va[31:16]; end
    t = (tag != "") ? tag : !v ? "R4" : em ? "R4" : ef ? "R6" : "R3";
    #5;
    checks++;
    if ({lk_hit, lk_miss, lk_fault, lk_paddr, miss_vpn} !== {eh, em, ef, ep, ev}) begin
      errors++;
      $display("FAIL %s: got hit=%b miss=%b fault=%b pa=%h mv=%h, expected hit=%b miss=%b fault=%b pa=%h mv=%h",
               t, lk_hit, lk_miss, lk_fault, lk_paddr, miss_vpn, eh, em, ef, ep, ev);
    end
    @(posedge clk);
    if (fl) model_clear();
    else if (fe) model_fill(fv, fp, fr);
    @(negedge clk);
  endtask

  task automatic look(input logic [15:0] vp, input logic [1:0] acc, input string tag);
    step(1, {vp, 16'h5a3c ^ {vp[7:0], vp[7:0]}}, acc, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fill(input logic [15:0] vp, input logic [11:0] pp, input logic [2:0] r);
    step(0, 0, 0, 1, vp, pp, r, 0, "R4");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; lk_valid = 0; lk_vaddr = 0; lk_acc = 0;
    fill_en = 0; fill_vpn = 0; fill_ppn = 0; fill_perm = 0; flush = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty after reset
    look(16'h0100, 0, "R1");
    look(16'hffff, 0, "R1");
    // R2: same-cycle lookup of a refill misses, next cycle hits
    step(1, 32'h0100_1234, 0, 1, 16'h0100, 12'h0a0, 3'b111, 0, "R2");
    look(16'h0100, 0, "R2");
    // fill the table, then exercise R6 rights
    for (int i = 1; i < N; i++) fill(16'h0100 + 16'(i), 12'(i * 5), 3'(i));
    for (int i = 0; i < N; i++) look(16'h0100 + 16'(i), 2'(i % 4), "");
    look(16'h0101, 0, "R6"); look(16'h0101, 1, "R6");
    look(16'h0102, 1, "R6"); look(16'h0104, 2, "R6");
    look(16'h0107, 3, "R6");
    // R7: refill of a cached page overwrites in place
    fill(16'h0105, 12'h777, 3'b001);
    look(16'h0105, 0, "R7"); look(16'h0100, 0, "R7");
    // R7: full table uses round-robin victims 0 then 1
    fill(16'h0200, 12'h200, 3'b111);
    look(16'h0100, 0, "R7"); look(16'h0200, 0, "R7"); look(16'h0101, 0, "R7");
    fill(16'h0201, 12'h201, 3'b111);
    look(16'h0101, 0, "R7"); look(16'h0102, 0, "R7");
    // R5: flush empties
    step(0, 0, 0, 0, 0, 0, 0, 1, "R5");
    look(16'h0200, 0, "R5"); look(16'h0102, 0, "R5");
    // R8: flush beats same-cycle fill
    fill(16'h0300, 12'h300, 3'b111);
    step(0, 0, 0, 1, 16'h0301, 12'h301, 3'b111, 1, "R8");
    look(16'h0301, 0, "R8"); look(16'h0300, 0, "R8");
    // R7: after flush, refills land in lowest invalid slots, pointer back at 0
    for (int i = 0; i < N + 3; i++) fill(16'h0400 + 16'(i), 12'(i), 3'b101);
    look(16'h0400, 0, "R7"); look(16'h0403, 0, "R7"); look(16'h0412, 2, "R7");
    // mixed random traffic on a small page space
    for (int k = 0; k < 3000; k++) begin
      automatic int r = $urandom_range(0, 99);
      step($urandom_range(0, 3) != 0, {12'h0, 4'($urandom), 16'($urandom)}, 2'($urandom),
           r < 30, {12'h0, 4'($urandom)}, 12'($urandom), 3'($urandom), r == 99, "");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule